// File: doc/BRIEF.md
# Bit-Serial Electron/Jet Discriminant

This block makes the final electron-versus-hadronic-jet decision for one energy map. Once per map period a frame marker presents four unsigned 16-bit summaries: the peak energy value M, the total energy S, the distance-weighted moment O and the neighbourhood peak sum P. The block evaluates the sign of `ALPHA*O - M*S - BETA*P`, with ALPHA = 134535 and BETA = 767665. This equals the sign of the normalised test `ALPHA*O/S - M - BETA*P/S` multiplied by S, so no division is needed.

All the arithmetic is bit-serial. S is converted to a serial stream, and the two constants are streamed out of the counter index. Three serial-by-parallel multipliers form `M*S`, `ALPHA*O` and `BETA*P` against registered words. Two one-bit subtractors combine the products, least significant bit first, in two's complement over a 48-bit window. The last bit of the window is the sign, and it is loaded into the output register together with a one-cycle completion strobe.

Top module: `serial_discriminant`

## Requirements
- R1: While reset is asserted and after it is released, `decision` and `dec_valid` are both 0 until the first window completes.
- R2: `decision` is 1 exactly when the signed value ALPHA*O - M*S - BETA*P is negative, with ALPHA = 134535 and BETA = 134535's companion constant 767665. M, S, O and P are the unsigned 16-bit values of `max_in`, `sum_in`, `mom_in` and `peak_in` sampled at the clock edge where `frame` is 1.
- R3: `dec_valid` is 1 for exactly one cycle. That cycle follows the 48th clock edge after the edge that sampled `frame`, and `decision` takes its new value at that same edge.
- R4: `decision` holds its value at every clock edge that does not raise `dec_valid`.
- R5: When `frame` is sampled again before the window completes, the evaluation restarts with the new operands. The earlier window produces no strobe, and the result appears 48 edges after the later frame.
- R6: Changes on the data inputs after the frame edge have no effect on the result of that window.
- R7: A difference of exactly zero gives `decision` = 0.
- R8: Without a frame marker, `dec_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame | input | 1 | Map marker; captures operands and starts a window |
| max_in | input | 16 | Maximum energy M, unsigned |
| sum_in | input | 16 | Total energy S, unsigned |
| mom_in | input | 16 | First moment O, unsigned |
| peak_in | input | 16 | Peak sum P, unsigned |
| decision | output | 1 | 1 when the weighted difference is negative |
| dec_valid | output | 1 | One-cycle strobe when `decision` is updated |

## Verification
The decision is tried over a full grid of edge operand values (0, 1, mid-range, 0x7FFF, 0xFFFF) in all four positions. Each product is maximised, zeroed or left alone in turn, which separates carry and borrow faults in each serial lane. Hand-picked operands put the difference at exactly zero and at minus fifteen, which tells a wrong sign convention apart from an off-by-one borrow. A pseudo-random sequence covers mixed magnitudes. Separate runs scramble the data inputs mid-window, re-issue the frame part way through, and hold the block idle, so that capture, restart and strobe timing are each observed at the outputs.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned WIN    = 48;
  localparam logic [WIN-1:0] ALPHA_C = 48'd134535;
  localparam logic [WIN-1:0] BETA_C  = 48'd767665;
endpackage

// File: rtl/sp_mult.sv
// Serial-by-parallel multiplier: one multiplier bit per cycle, LSB first,
// one product bit out per cycle.
module sp_mult #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         x_bit,
  input  logic [W-1:0] y,
  output logic         p_bit
);
  logic [W:0]   acc_q, acc_d;
  logic [W+1:0] sum;

  always_comb begin
    sum   = {1'b0, acc_q} + (x_bit ? {2'b00, y} : '0);
    p_bit = sum[0];
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum[W+1:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/serial_sub.sv
// One-bit two's complement subtractor with a registered borrow.
module serial_sub (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic d
);
  logic brw_q, brw_d;

  always_comb begin
    d     = a ^ b ^ brw_q;
    brw_d = brw_q;
    if (clr)     brw_d = 1'b0;
    else if (en) brw_d = (~a & b) | (~(a ^ b) & brw_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brw_q <= 1'b0;
    else        brw_q <= brw_d;
  end
endmodule

// File: rtl/window_ctl.sv
// Bit-index counter for the serial window; restarts on every frame.
module window_ctl #(
  parameter int unsigned WIN   = 48,
  localparam int unsigned CNT_W = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] idx,
  output logic             last
);
  logic             busy_d;
  logic [CNT_W-1:0] idx_d;

  assign last = busy && (idx == CNT_W'(WIN-1));

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (busy) begin
      idx_d  = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else begin
      busy <= busy_d;
      idx  <= idx_d;
    end
  end
endmodule

// File: rtl/serial_discriminant.sv
module serial_discriminant
  import disc_pkg::*;
#(
  parameter int unsigned     W     = DATA_W,
  parameter int unsigned     NWIN  = WIN,
  parameter logic [NWIN-1:0] ALPHA = ALPHA_C,
  parameter logic [NWIN-1:0] BETA  = BETA_C,
  localparam int unsigned    CNT_W = $clog2(NWIN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame,
  input  logic [W-1:0] max_in,
  input  logic [W-1:0] sum_in,
  input  logic [W-1:0] mom_in,
  input  logic [W-1:0] peak_in,
  output logic         decision,
  output logic         dec_valid
);
  logic             busy, last;
  logic [CNT_W-1:0] idx;
  logic [W-1:0]     s_sh_q, s_sh_d;
  logic [W-1:0]     m_q, o_q, p_q;
  logic             a_bit, b_bit;
  logic             ms_bit, ao_bit, bp_bit, t_bit, d_bit;
  logic             dec_d;

  window_ctl #(.WIN(NWIN)) u_win (
    .clk(clk), .rst_n(rst_n), .start(frame),
    .busy(busy), .idx(idx), .last(last)
  );

  // Parallel-to-serial conversion of S, zero fill above its width
  always_comb begin
    s_sh_d = s_sh_q;
    if (frame)     s_sh_d = sum_in;
    else if (busy) s_sh_d = {1'b0, s_sh_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sh_q <= '0;
      m_q    <= '0;
      o_q    <= '0;
      p_q    <= '0;
    end else begin
      s_sh_q <= s_sh_d;
      if (frame) begin
        m_q <= max_in;
        o_q <= mom_in;
        p_q <= peak_in;
      end
    end
  end

  // Constants streamed by bit index
  assign a_bit = ALPHA[idx];
  assign b_bit = BETA[idx];

  sp_mult #(.W(W)) u_ms (
    .clk(clk), .rst_n(rst_n), .clr(frame), .en(busy),
    .x_bit(s_sh_q[0]), .y(m_q), .p_bit(ms_bit)
  );
  sp_mult #(.W(W)) u_ao (
    .clk(clk), .rst_n(rst_n), .clr(frame), .en(busy),
    .x_bit(a_bit), .y(o_q), .p_bit(ao_bit)
  );
  sp_mult #(.W(W)) u_bp (
    .clk(clk), .rst_n(rst_n), .clr(frame), .en(busy),
    .x_bit(b_bit), .y(p_q), .p_bit(bp_bit)
  );

  serial_sub u_sub1 (
    .clk(clk), .rst_n(rst_n), .clr(frame), .en(busy),
    .a(ao_bit), .b(ms_bit), .d(t_bit)
  );
  serial_sub u_sub2 (
    .clk(clk), .rst_n(rst_n), .clr(frame), .en(busy),
    .a(t_bit), .b(bp_bit), .d(d_bit)
  );

  // Output register loaded by the finish strobe with the sign bit
  always_comb begin
    dec_d = decision;
    if (last && !frame) dec_d = d_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decision  <= 1'b0;
      dec_valid <= 1'b0;
    end else begin
      decision  <= dec_d;
      dec_valid <= last && !frame;
    end
  end
endmodule

// File: rtl/disc_checker.sv
module disc_checker #(
  parameter int unsigned WIN = 48,
  localparam int unsigned SW = $clog2(WIN + 3)
) (
  input logic clk,
  input logic rst_n,
  input logic frame,
  input logic decision,
  input logic dec_valid
);
  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  since <= '0;
    else if (frame)                              since <= SW'(1);
    else if (since != '0 && since < SW'(WIN+2))  since <= since + 1'b1;
  end

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  p_strobe_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (since == SW'(WIN+1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(decision));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since == '0) |-> !dec_valid);
endmodule

bind serial_discriminant disc_checker #(.WIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame(frame),
  .decision(decision), .dec_valid(dec_valid)
);

// File: tb/test_serial_discriminant.sv
module test_serial_discriminant;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame;
  logic [15:0] max_in, sum_in, mom_in, peak_in;
  logic        decision, dec_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit prev_dec = 1'b0;

  always #2 clk = ~clk;

  serial_discriminant i_serial_discriminant (
    .clk(clk), .rst_n(rst_n), .frame(frame),
    .max_in(max_in), .sum_in(sum_in), .mom_in(mom_in), .peak_in(peak_in),
    .decision(decision), .dec_valid(dec_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic bit exp_dec(input logic [15:0] m, s, o, p);
    longint d;
    d = 64'sd134535 * longint'(o) - longint'(m) * longint'(s)
        - 64'sd767665 * longint'(p);
    return d < 0;
  endfunction

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives a frame, optionally scrambles inputs afterwards, and checks
  // strobe timing, hold and result.
  task automatic run_frame(input logic [15:0] m, s, o, p, input bit scramble);
    bit e;
    bit early;
    e = exp_dec(m, s, o, p);
    early = 1'b0;
    @(negedge clk);
    frame = 1'b1; max_in = m; sum_in = s; mom_in = o; peak_in = p;
    for (int i = 1; i <= 49; i++) begin
      @(negedge clk);
      if (i == 1) begin
        frame = 1'b0;
        if (scramble) begin
          max_in = ~m; sum_in = ~s; mom_in = ~o; peak_in = ~p;
        end
      end
      if (i < 49 && (dec_valid || decision != prev_dec)) early = 1'b1;
    end
    check(!early, "R4 hold during window", early, 0);
    check(dec_valid == 1'b1, "R3 strobe at 48 edges", dec_valid, 1);
    check(decision == e, scramble ? "R6 result after scramble" : "R2 decision",
          decision, e);
    prev_dec = decision;
    @(negedge clk);
    check(dec_valid == 1'b0, "R3 single strobe", dec_valid, 0);
  endtask

  logic [15:0] vals [5] = '{16'h0000, 16'h0001, 16'h00ff, 16'h7fff, 16'hffff};

  initial begin
    bit seen;
    logic [31:0] lfsr;
    rst_n = 1'b0; frame = 1'b0;
    max_in = '0; sum_in = '0; mom_in = '0; peak_in = '0;
    repeat (3) @(negedge clk);
    check(decision == 1'b0 && dec_valid == 1'b0, "R1 in reset",
          {decision, dec_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(decision == 1'b0 && dec_valid == 1'b0, "R1 after release",
          {decision, dec_valid}, 0);

    // R8: idle, no strobe
    seen = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (dec_valid) seen = 1'b1;
    end
    check(!seen, "R8 idle no strobe", seen, 0);

    // R7: exact zero difference (15*8969 == 134535), and one step below
    run_frame(16'd15, 16'd8969, 16'd1, 16'd0, 1'b0);
    check(decision == 1'b0, "R7 zero gives 0", decision, 0);
    run_frame(16'd15, 16'd8970, 16'd1, 16'd0, 1'b0);
    check(decision == 1'b1, "R2 minus fifteen gives 1", decision, 1);

    // R2: grid of edge values
    foreach (vals[a]) foreach (vals[b]) foreach (vals[c]) foreach (vals[d])
      run_frame(vals[a], vals[b], vals[c], vals[d], 1'b0);

    // R2: pseudo-random operands
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 150; k++) begin
      logic [15:0] m, s, o, p;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; m = lfsr[31:16];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; s = lfsr[31:16];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; o = lfsr[31:16];
      lfsr = lfsr * 32'd1664525 + 32'd1013904223; p = lfsr[27:12] >> (k % 8);
      run_frame(m, s, o, p, 1'b0);
    end

    // R6: inputs change right after capture
    run_frame(16'd100, 16'd200, 16'd50000, 16'd3, 1'b1);
    run_frame(16'hffff, 16'hffff, 16'd2, 16'd0, 1'b1);
    run_frame(16'd0, 16'd0, 16'd0, 16'd1, 1'b1);

    // R5: restart mid-window; first operands give 0, second give 1
    @(negedge clk);
    frame = 1'b1; max_in = 16'd0; sum_in = 16'd0; mom_in = 16'd9; peak_in = 16'd0;
    @(negedge clk);
    frame = 1'b0;
    seen = 1'b0;
    repeat (19) begin
      @(negedge clk);
      if (dec_valid) seen = 1'b1;
    end
    frame = 1'b1; max_in = 16'hffff; sum_in = 16'hffff; mom_in = 16'd0; peak_in = 16'd5;
    for (int i = 1; i <= 49; i++) begin
      @(negedge clk);
      if (i == 1) frame = 1'b0;
      if (i < 49 && dec_valid) seen = 1'b1;
    end
    check(!seen, "R5 no strobe from abandoned window", seen, 0);
    check(dec_valid == 1'b1, "R5 strobe 48 after restart", dec_valid, 1);
    check(decision == 1'b1, "R5 result from later operands", decision, 1);
    prev_dec = decision;
    @(negedge clk);
    check(dec_valid == 1'b0, "R3 single strobe after restart", dec_valid, 0);

    // R4/R8: hold with no further frames
    seen = 1'b0;
    repeat (80) begin
      @(negedge clk);
      if (dec_valid || decision != prev_dec) seen = 1'b1;
    end
    check(!seen, "R4 decision held while idle", seen, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule